// File: doc/BRIEF.md
# Store Multiple Word Sequencer

This block carries out a store-multiple-word operation over several cycles. A command gives a first register number, a base register index with that register's value, and a signed 16-bit displacement. The sequencer then walks from the first register up to the highest register. For each register it reads the register file through a read port and issues one 32-bit memory write through a valid/ready port. Each write carries the low word of the register it just read.

The first write address is the base plus the sign-extended displacement. When the base register index is zero, the base counts as zero whatever value comes with it. Every later write goes 4 bytes above the one before it. The read port is combinational: the register file returns the data for `rfRdIdx` in the same cycle. The sequencer captures that data in its READ state and then presents it in its WRITE state. A write stays on the port until memory accepts it. After the final accepted write, `done` pulses for one cycle and the block becomes idle again. No other architectural state is changed.

Top module: `multi_word_store_seq`

## Requirements
- R1: With a nonzero base index, the first write address equals cmdBaseVal plus cmdDisp sign-extended to ADDR_W bits.
- R2: With a base index of 0, the first write address equals cmdDisp sign-extended, and cmdBaseVal has no effect.
- R3: A command with first register S produces exactly NUM_REGS-S writes, for registers S, S+1, ... NUM_REGS-1 in that order. A start of 31 gives one write and a start of 0 gives 32 writes.
- R4: The data of each write equals bits [31:0] of the register being stored, as returned on rfRdData for that rfRdIdx.
- R5: Each write address is 4 greater than the previous write address of the same command.
- R6: While memValid is high and memReady is low, memValid, memAddr and memData hold their values in the next cycle. The address and the register number advance only when a write is accepted.
- R7: done is high for exactly one cycle, in the cycle right after the last accepted write. In the next cycle done is low and cmdReady is high.
- R8: cmdReady is high only when the block is idle. A cmdValid seen while cmdReady is low is ignored and does not change the addresses or data of the running command.
- R9: After reset, cmdReady is 1 and memValid, rfRdEn and done are 0.
- R10: Address arithmetic wraps modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command request |
| cmdReady | output | 1 | High when idle and able to take a command |
| cmdStartReg | input | IDX_W (5) | First register to store |
| cmdBaseIdx | input | IDX_W (5) | Base register index; 0 means a zero base |
| cmdBaseVal | input | ADDR_W (64) | Value of the base register |
| cmdDisp | input | DISP_W (16) | Signed displacement |
| rfRdEn | output | 1 | Register read strobe |
| rfRdIdx | output | IDX_W (5) | Register being read |
| rfRdData | input | REG_W (64) | Register contents, combinational from rfRdIdx |
| memValid | output | 1 | Write request |
| memReady | input | 1 | Memory accepts the write |
| memAddr | output | ADDR_W (64) | Byte address of the 4-byte write |
| memData | output | WORD_W (32) | Word to write |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench uses the default parameters: 64-bit addresses and registers, 32-bit words, 32 registers and a 16-bit displacement. With these values a start register of 0 gives the full 32-write run, and a start of 31 gives the single-write case. A base value a few bytes below 2^64 makes the 4-byte stepping wrap through zero partway through a command. Random stalls on the memory ready line exercise the hold rule at every point in the sequence.

// File: rtl/mws_pkg.sv
package mws_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } seqState_t;

  typedef struct packed {
    logic loadCmd;
    logic loadWord;
    logic advance;
  } dpStrobe_t;
endpackage

// File: rtl/mws_dpath.sv
module mws_dpath
  import mws_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int REG_W    = 64,
  parameter int WORD_W   = 32,
  parameter int DISP_W   = 16,
  parameter int NUM_REGS = 32,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpStrobe_t         strobe,
  input  logic [IDX_W-1:0]  cmdStartReg,
  input  logic [IDX_W-1:0]  cmdBaseIdx,
  input  logic [ADDR_W-1:0] cmdBaseVal,
  input  logic [DISP_W-1:0] cmdDisp,
  input  logic [REG_W-1:0]  rfRdData,
  output logic [IDX_W-1:0]  regIdx,
  output logic [ADDR_W-1:0] curAddr,
  output logic [WORD_W-1:0] wordOut,
  output logic              lastReg
);
  localparam int STEP_BYTES = WORD_W / 8;
  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(NUM_REGS - 1);
  localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(STEP_BYTES);

  logic [ADDR_W-1:0] baseEff;
  logic [ADDR_W-1:0] dispExt;

  // a zero base index selects a zero base, not register 0's value
  assign baseEff = (cmdBaseIdx == '0) ? '0 : cmdBaseVal;
  assign dispExt = {{(ADDR_W-DISP_W){cmdDisp[DISP_W-1]}}, cmdDisp};
  assign lastReg = (regIdx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      regIdx  <= '0;
      curAddr <= '0;
      wordOut <= '0;
    end else begin
      if (strobe.loadCmd) begin
        regIdx  <= cmdStartReg;
        curAddr <= baseEff + dispExt;
      end else if (strobe.advance) begin
        regIdx  <= regIdx + 1'b1;
        curAddr <= curAddr + STEP;
      end
      if (strobe.loadWord) begin
        wordOut <= rfRdData[WORD_W-1:0];
      end
    end
  end
endmodule

// File: rtl/mws_ctrl.sv
module mws_ctrl
  import mws_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cmdValid,
  input  logic      memReady,
  input  logic      lastReg,
  output logic      cmdReady,
  output logic      rfRdEn,
  output logic      memValid,
  output logic      done,
  output dpStrobe_t strobe
);
  seqState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (cmdValid) stateNext = ST_READ;
      ST_READ:  stateNext = ST_WRITE;
      ST_WRITE: if (memReady) stateNext = lastReg ? ST_DONE : ST_READ;
      ST_DONE:  stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  assign cmdReady        = (state == ST_IDLE);
  assign rfRdEn          = (state == ST_READ);
  assign memValid        = (state == ST_WRITE);
  assign done            = (state == ST_DONE);
  assign strobe.loadCmd  = cmdReady && cmdValid;
  assign strobe.loadWord = rfRdEn;
  assign strobe.advance  = memValid && memReady;
endmodule

// File: rtl/multi_word_store_seq.sv
module multi_word_store_seq
  import mws_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int REG_W    = 64,
  parameter int WORD_W   = 32,
  parameter int DISP_W   = 16,
  parameter int NUM_REGS = 32,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [IDX_W-1:0]  cmdStartReg,
  input  logic [IDX_W-1:0]  cmdBaseIdx,
  input  logic [ADDR_W-1:0] cmdBaseVal,
  input  logic [DISP_W-1:0] cmdDisp,
  output logic              rfRdEn,
  output logic [IDX_W-1:0]  rfRdIdx,
  input  logic [REG_W-1:0]  rfRdData,
  output logic              memValid,
  input  logic              memReady,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memData,
  output logic              done
);
  dpStrobe_t strobe;
  logic      lastReg;

  mws_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmdValid (cmdValid),
    .memReady (memReady),
    .lastReg  (lastReg),
    .cmdReady (cmdReady),
    .rfRdEn   (rfRdEn),
    .memValid (memValid),
    .done     (done),
    .strobe   (strobe)
  );

  mws_dpath #(
    .ADDR_W   (ADDR_W),
    .REG_W    (REG_W),
    .WORD_W   (WORD_W),
    .DISP_W   (DISP_W),
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W)
  ) u_dpath (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .cmdStartReg (cmdStartReg),
    .cmdBaseIdx  (cmdBaseIdx),
    .cmdBaseVal  (cmdBaseVal),
    .cmdDisp     (cmdDisp),
    .rfRdData    (rfRdData),
    .regIdx      (rfRdIdx),
    .curAddr     (memAddr),
    .wordOut     (memData),
    .lastReg     (lastReg)
  );
endmodule

// File: rtl/mws_checker.sv
module mws_checker #(
  parameter int ADDR_W = 64,
  parameter int WORD_W = 32,
  parameter int IDX_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmdReady,
  input logic              rfRdEn,
  input logic [IDX_W-1:0]  rfRdIdx,
  input logic              memValid,
  input logic              memReady,
  input logic [ADDR_W-1:0] memAddr,
  input logic [WORD_W-1:0] memData,
  input logic              done
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_W / 8);

  logic              havePrevAddr;
  logic              havePrevIdx;
  logic [ADDR_W-1:0] prevAddr;
  logic [IDX_W-1:0]  prevIdx;

  always_ff @(posedge clk) begin
    if (!rst_n || cmdReady) begin
      havePrevAddr <= 1'b0;
      havePrevIdx  <= 1'b0;
      prevAddr     <= '0;
      prevIdx      <= '0;
    end else begin
      if (memValid && memReady) begin
        havePrevAddr <= 1'b1;
        prevAddr     <= memAddr;
      end
      if (rfRdEn) begin
        havePrevIdx <= 1'b1;
        prevIdx     <= rfRdIdx;
      end
    end
  end

  a_r6_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (memValid && !memReady) |=> (memValid && $stable(memAddr) && $stable(memData)));

  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (memValid && memReady && havePrevAddr) |-> (memAddr == prevAddr + STEP));

  a_r3_reg_ascend: assert property (@(posedge clk) disable iff (!rst_n)
    (rfRdEn && havePrevIdx) |-> (rfRdIdx == prevIdx + 1'b1));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && cmdReady));

  a_r7_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(memValid && memReady));

  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmdReady, rfRdEn, memValid, done}));
endmodule

bind multi_word_store_seq mws_checker #(
  .ADDR_W (ADDR_W),
  .WORD_W (WORD_W),
  .IDX_W  (IDX_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmdReady (cmdReady),
  .rfRdEn   (rfRdEn),
  .rfRdIdx  (rfRdIdx),
  .memValid (memValid),
  .memReady (memReady),
  .memAddr  (memAddr),
  .memData  (memData),
  .done     (done)
);

// File: tb/multi_word_store_seq_bench.sv
module multi_word_store_seq_bench;
  localparam int ADDR_W = 64;
  localparam int REG_W  = 64;
  localparam int WORD_W = 32;
  localparam int DISP_W = 16;
  localparam int NREGS  = 32;
  localparam int IDX_W  = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmdValid = 1'b0;
  logic              cmdReady;
  logic [IDX_W-1:0]  cmdStartReg = '0;
  logic [IDX_W-1:0]  cmdBaseIdx = '0;
  logic [ADDR_W-1:0] cmdBaseVal = '0;
  logic [DISP_W-1:0] cmdDisp = '0;
  logic              rfRdEn;
  logic [IDX_W-1:0]  rfRdIdx;
  logic [REG_W-1:0]  rfRdData;
  logic              memValid;
  logic              memReady = 1'b0;
  logic [ADDR_W-1:0] memAddr;
  logic [WORD_W-1:0] memData;
  logic              done;

  logic [REG_W-1:0]  gpr [NREGS];
  logic [ADDR_W-1:0] wrAddr [64];
  logic [WORD_W-1:0] wrData [64];
  int                wrN = 0;
  int                readyPct = 100;
  int                checks = 0;
  int                errors = 0;
  int                cycles = 0;
  logic              prevStall = 1'b0;
  logic [ADDR_W-1:0] stallAddr = '0;
  logic [WORD_W-1:0] stallData = '0;

  always #4 clk = ~clk;

  assign rfRdData = gpr[rfRdIdx];

  multi_word_store_seq u_multi_word_store_seq (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdStartReg(cmdStartReg), .cmdBaseIdx(cmdBaseIdx), .cmdBaseVal(cmdBaseVal),
    .cmdDisp(cmdDisp), .rfRdEn(rfRdEn), .rfRdIdx(rfRdIdx), .rfRdData(rfRdData),
    .memValid(memValid), .memReady(memReady), .memAddr(memAddr),
    .memData(memData), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] firstAddr(input logic [IDX_W-1:0] bidx,
      input logic [ADDR_W-1:0] bval, input logic [DISP_W-1:0] disp);
    logic [ADDR_W-1:0] b;
    b = (bidx == 0) ? '0 : bval;
    return b + {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
  endfunction

  // memory model and stall observer
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst_n) begin
      if (prevStall) begin
        check(memValid && memAddr == stallAddr && memData == stallData,
              "R6", "stalled write changed", {32'b0, memData}, {32'b0, stallData});
      end
      prevStall <= memValid && !memReady;
      stallAddr <= memAddr;
      stallData <= memData;
      if (memValid && memReady && wrN < 64) begin
        wrAddr[wrN] = memAddr;
        wrData[wrN] = memData;
        wrN = wrN + 1;
      end
    end
  end

  always @(negedge clk) begin
    memReady <= (int'($urandom % 100) < readyPct);
  end

  task automatic runOp(input logic [IDX_W-1:0] start, input logic [IDX_W-1:0] bidx,
                       input logic [ADDR_W-1:0] bval, input logic [DISP_W-1:0] disp,
                       input bit intrude, input string tag);
    logic [ADDR_W-1:0] a0;
    int expN;
    int waitCnt;
    a0   = firstAddr(bidx, bval, disp);
    expN = NREGS - int'(start);
    @(negedge clk);
    check(cmdReady == 1'b1, "R8", {tag, " ready before command"}, 64'(cmdReady), 64'd1);
    wrN = 0;
    cmdValid = 1'b1; cmdStartReg = start; cmdBaseIdx = bidx;
    cmdBaseVal = bval; cmdDisp = disp;
    @(negedge clk);
    cmdValid = 1'b0;
    if (intrude) begin
      // R8: commands while busy are ignored
      check(cmdReady == 1'b0, "R8", {tag, " busy after accept"}, 64'(cmdReady), 64'd0);
      cmdValid = 1'b1; cmdStartReg = 5'd30; cmdBaseIdx = 5'd3;
      cmdBaseVal = 64'hDEAD_0000; cmdDisp = 16'h0100;
      repeat (3) @(negedge clk);
      cmdValid = 1'b0;
    end
    waitCnt = 0;
    while (!done && waitCnt < 3000) begin
      @(negedge clk);
      waitCnt++;
    end
    check(done == 1'b1, "R7", {tag, " done seen"}, 64'(done), 64'd1);
    check(wrN == expN, "R3", {tag, " write count"}, 64'(wrN), 64'(expN));
    for (int k = 0; k < expN && k < wrN; k++) begin
      check(wrAddr[k] == a0 + 64'(4 * k), (k == 0) ? ((bidx == 0) ? "R2" : "R1") : "R5",
            {tag, " address"}, wrAddr[k], a0 + 64'(4 * k));
      check(wrData[k] == gpr[int'(start) + k][31:0], "R4", {tag, " data"},
            {32'b0, wrData[k]}, {32'b0, gpr[int'(start) + k][31:0]});
    end
    @(negedge clk);
    check(!done && cmdReady, "R7", {tag, " idle after done"},
          {62'b0, done, cmdReady}, 64'd1);
    check(wrN == expN, "R6", {tag, " no extra writes"}, 64'(wrN), 64'(expN));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NREGS; i++) gpr[i] = {$urandom, $urandom};
    repeat (3) @(negedge clk);
    check(cmdReady == 1'b1 && !memValid && !rfRdEn && !done, "R9", "reset outputs",
          {60'b0, cmdReady, memValid, rfRdEn, done}, 64'h8);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmdReady == 1'b1 && !memValid && !done, "R9", "after reset release",
          {61'b0, cmdReady, memValid, done}, 64'h4);

    readyPct = 100;
    runOp(5'd31, 5'd4, 64'h0000_0000_0000_1000, 16'h0010, 1'b0, "R3 single");
    readyPct = 50;
    runOp(5'd0, 5'd7, 64'h0000_0000_8000_0000, 16'hFFF0, 1'b0, "R3 full");
    runOp(5'd20, 5'd0, 64'h1234_5678_9ABC_DEF0, 16'h0040, 1'b0, "R2 zero base");
    runOp(5'd10, 5'd9, 64'h0000_0000_0001_0000, 16'h8000, 1'b1, "R8 intrude");
    runOp(5'd26, 5'd2, 64'hFFFF_FFFF_FFFF_FFF0, 16'h0004, 1'b0, "R10 wrap");
    readyPct = 30;
    runOp(5'd16, 5'd1, 64'h0000_0000_0000_0000, 16'h7FFC, 1'b0, "R1 max disp");
    for (int n = 0; n < 20; n++) begin
      readyPct = 20 + int'($urandom % 81);
      for (int i = 0; i < NREGS; i++) gpr[i] = {$urandom, $urandom};
      runOp(5'($urandom), 5'($urandom % 4), {$urandom, $urandom}, 16'($urandom),
            1'($urandom), "random");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles >= 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule